// File: doc/BRIEF.md
# Codec-Side Serial Audio Link Frame Engine

This block is the digital front end of an audio codec that talks to its controller over a five-wire, time-division-multiplexed serial link. Each frame lasts 256 bit clocks. It opens with a 16-bit tag slot and continues with twelve 20-bit data slots. Each tag bit says whether one slot of the same frame carries data. The controller marks the start of a frame by raising SYNC and holding it high for the 16 clocks of the tag phase.

On the receive side the engine samples SYNC and the controller's data line on falling bit-clock edges. It aligns to the rising edge of SYNC and shifts in the tag and the slots MSB first. Once the frame is complete it publishes them all together as parallel words with per-slot valid flags and a one-cycle strobe. On the transmit side it builds the frame that goes back to the controller, changing its output on rising edges. The tag holds the codec-ready flag and the per-slot valid flags, and the slots come from the payload inputs. A slot whose flag is clear is forced to zero. The engine also reports SYNC high phases of the wrong length. While the link is powered down it ignores framing and watches for the SYNC pulse that signals a warm reset.

Top module: `aclink_codec_if`

## Requirements
- R1: A frame starts at the falling bit-clock edge that first samples `sync_in` high after a low sample; `ctl_sdata` at that edge is tag bit 15. The tag (16 bits) and twelve 20-bit slots are shifted in MSB first. At the falling edge that samples frame bit 255, `rx_frame` pulses for one cycle, and `rx_tag` and `rx_slot_data` update at that same edge (slot 1 in bits 19:0, slot 12 in bits 239:220).
- R2: `rx_slot_vld[s]` equals received tag bit 14-s (slot s+1). Slot data whose flag is clear is reported as zero, whatever the controller sent.
- R3: `codec_sdata` changes on rising edges. It drives tag bit 15 on the rising edge right after the frame start is sampled, then one bit per clock. The outgoing tag is bit 15 = `codec_rdy`, bits 14..3 = `tx_slot_vld[0..11]`, and bits 2..0 = 0. The twelve slots follow MSB first, slot 1 from `tx_slot_data[19:0]`. The payload is taken at the rising edge that drives tag bit 15.
- R4: An outgoing slot whose valid flag is clear is driven as all zeros. After the 256th bit, `codec_sdata` stays low until the next frame start.
- R5: When `sync_in` falls after a high run whose length is not 16 samples, `frame_err` pulses at the falling edge that samples the low level. The frame is still decoded from its rising-edge alignment.
- R6: A new SYNC rising edge inside a frame abandons that frame without a strobe and realigns to the new frame. This also holds when the edge lands on the position of bit 255.
- R7: While `link_pd` is high, no frame is decoded, `rx_frame` and `frame_err` stay low and `codec_sdata` stays low. Decoding resumes with the first frame after `link_pd` drops.
- R8: While `link_pd` is high, a SYNC high run of at least 4 samples followed by a low sample gives a one-cycle `warm_rst` pulse at the falling edge that samples the low level. Shorter runs give none.
- R9: While `rst_n` is low and after its release, all outputs are zero until a frame produces them.
- R10: If the SYNC fall that ends a wrong-length high run lands on the frame's last bit, `frame_err` and `rx_frame` pulse in the same cycle, and the frame data is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | Frame sync from the controller |
| ctl_sdata | input | 1 | Serial data from the controller |
| link_pd | input | 1 | Link powered-down state from the register block |
| codec_rdy | input | 1 | Codec-ready flag for outgoing tag bit 15 |
| tx_slot_vld | input | 12 | Outgoing valid flag per slot (bit s = slot s+1) |
| tx_slot_data | input | 240 | Outgoing slot payloads, 20 bits per slot |
| codec_sdata | output | 1 | Serial data to the controller |
| rx_frame | output | 1 | One-cycle strobe when a received frame is complete |
| rx_tag | output | 16 | Received tag word |
| rx_slot_vld | output | 12 | Received valid flag per slot |
| rx_slot_data | output | 240 | Received slot words, 20 bits per slot |
| frame_err | output | 1 | Pulse on a SYNC high run of the wrong length |
| warm_rst | output | 1 | Warm-reset pulse while the link is powered down |

## Verification
Two things can coincide in one falling-edge cycle: the framing-error pulse and the frame-complete strobe. This happens when the controller holds SYNC high for 255 clocks, so that its fall is sampled exactly at bit 255. The bench drives that frame and expects both pulses in that one cycle, with the published slots still matching the model. A second collision puts a new SYNC rise at the bit-255 position. There the restart must win, so no strobe may appear.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
   // Receive-side frame state
   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_TAG  = 2'd1,
      RX_DATA = 2'd2
   } rx_state_e;

   localparam int unsigned TAG_W_DEF     = 16;
   localparam int unsigned SLOT_W_DEF    = 20;
   localparam int unsigned NUM_SLOTS_DEF = 12;
   localparam int unsigned SYNC_HI_DEF   = 16;
   localparam int unsigned WARM_MIN_DEF  = 4;
endpackage

// File: rtl/aclink_rx.sv
module aclink_rx
   import aclink_pkg::*;
#(
   parameter int unsigned TAG_W        = TAG_W_DEF,
   parameter int unsigned SLOT_W       = SLOT_W_DEF,
   parameter int unsigned NUM_SLOTS    = NUM_SLOTS_DEF,
   parameter int unsigned SYNC_HIGH    = SYNC_HI_DEF,
   parameter bit          ZERO_INVALID = 1'b1
)(
   input  logic                          bclk,
   input  logic                          rst_n,
   input  logic                          sync_i,
   input  logic                          sdata_i,
   input  logic                          link_pd,
   output logic                          start_o,
   output logic                          frame_o,
   output logic                          err_o,
   output logic [TAG_W-1:0]              tag_o,
   output logic [NUM_SLOTS-1:0]          vld_o,
   output logic [NUM_SLOTS*SLOT_W-1:0]   data_o
);
   localparam int unsigned FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
   localparam int unsigned BIT_W      = $clog2(SLOT_W);
   localparam int unsigned IDX_W      = $clog2(NUM_SLOTS);
   localparam logic [CNT_W-1:0] SYNC_HIGH_C = CNT_W'(SYNC_HIGH);
   localparam logic [BIT_W-1:0] TAG_LAST    = BIT_W'(TAG_W - 1);
   localparam logic [BIT_W-1:0] SLOT_LAST   = BIT_W'(SLOT_W - 1);
   localparam logic [IDX_W-1:0] IDX_LAST    = IDX_W'(NUM_SLOTS - 1);

   if (TAG_W > SLOT_W) begin : g_bad_tag
      $error("aclink_rx: tag slot wider than data slot");
   end
   if (NUM_SLOTS + 1 > TAG_W) begin : g_bad_slots
      $error("aclink_rx: tag too narrow for slot flags");
   end
   if (NUM_SLOTS < 2) begin : g_bad_count
      $error("aclink_rx: at least two data slots required");
   end

   rx_state_e                state;
   logic                     sync_q;
   logic [CNT_W-1:0]         hi_cnt;
   logic [BIT_W-1:0]         bit_idx;
   logic [IDX_W-1:0]         slot_idx;
   logic [SLOT_W-1:0]        shreg;
   logic [SLOT_W-1:0]        next_sh;
   logic [TAG_W-1:0]         tag_work;
   logic [SLOT_W-1:0]        work [NUM_SLOTS];
   logic [NUM_SLOTS-1:0]     vld_next;
   logic [NUM_SLOTS*SLOT_W-1:0] pub_data;
   logic                     sync_rise;
   logic                     sync_fall;
   logic                     slot_done;

   assign sync_rise = sync_i & ~sync_q;
   assign sync_fall = ~sync_i & sync_q;
   assign next_sh   = {shreg[SLOT_W-2:0], sdata_i};
   assign slot_done = !link_pd && !sync_rise && (state == RX_DATA) && (bit_idx == SLOT_LAST);

   // Publish view: earlier slots from the work store, the last one straight from the shifter
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [SLOT_W-1:0] raw;
      if (s == NUM_SLOTS - 1) begin : g_last
         assign raw = next_sh;
      end else begin : g_mid
         assign raw = work[s];
      end
      assign vld_next[s] = tag_work[TAG_W-2-s];
      if (ZERO_INVALID) begin : g_mask
         assign pub_data[s*SLOT_W +: SLOT_W] = vld_next[s] ? raw : '0;
      end else begin : g_pass
         assign pub_data[s*SLOT_W +: SLOT_W] = raw;
      end
   end

   // Slot store needs no reset: it is only read after being written in the same frame
   always_ff @(negedge bclk) begin
      if (slot_done) work[slot_idx] <= next_sh;
   end

   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         sync_q   <= 1'b0;
         hi_cnt   <= '0;
         bit_idx  <= '0;
         slot_idx <= '0;
         shreg    <= '0;
         tag_work <= '0;
         start_o  <= 1'b0;
         frame_o  <= 1'b0;
         err_o    <= 1'b0;
         tag_o    <= '0;
         vld_o    <= '0;
         data_o   <= '0;
      end else begin
         sync_q  <= sync_i;
         start_o <= 1'b0;
         frame_o <= 1'b0;
         err_o   <= 1'b0;

         if (sync_rise)                     hi_cnt <= CNT_W'(1);
         else if (sync_i && hi_cnt != '1)   hi_cnt <= hi_cnt + CNT_W'(1);

         if (!link_pd && sync_fall && hi_cnt != SYNC_HIGH_C) err_o <= 1'b1;

         if (link_pd) begin
            state <= RX_IDLE;
         end else if (sync_rise) begin
            state   <= RX_TAG;
            start_o <= 1'b1;
            bit_idx <= BIT_W'(1);
            shreg   <= {{(SLOT_W-1){1'b0}}, sdata_i};
         end else begin
            case (state)
               RX_TAG: begin
                  shreg <= next_sh;
                  if (bit_idx == TAG_LAST) begin
                     tag_work <= next_sh[TAG_W-1:0];
                     bit_idx  <= '0;
                     slot_idx <= '0;
                     state    <= RX_DATA;
                  end else begin
                     bit_idx <= bit_idx + BIT_W'(1);
                  end
               end
               RX_DATA: begin
                  shreg <= next_sh;
                  if (bit_idx == SLOT_LAST) begin
                     bit_idx <= '0;
                     if (slot_idx == IDX_LAST) begin
                        frame_o <= 1'b1;
                        tag_o   <= tag_work;
                        vld_o   <= vld_next;
                        data_o  <= pub_data;
                        state   <= RX_IDLE;
                     end else begin
                        slot_idx <= slot_idx + IDX_W'(1);
                     end
                  end else begin
                     bit_idx <= bit_idx + BIT_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_START_ON_RISE: assert property (@(negedge bclk) disable iff (!rst_n)
      start_o |-> $past(sync_i) && !$past(link_pd)); // R1
   AST_FRAME_SINGLE: assert property (@(negedge bclk) disable iff (!rst_n)
      frame_o |=> !frame_o); // R1
   AST_ERR_ON_FALL: assert property (@(negedge bclk) disable iff (!rst_n)
      err_o |-> !$past(sync_i) && $past(sync_i, 2)); // R5
   AST_PD_SILENT: assert property (@(negedge bclk) disable iff (!rst_n)
      link_pd |=> !frame_o && !err_o); // R7
endmodule

// File: rtl/aclink_tx.sv
module aclink_tx
   import aclink_pkg::*;
#(
   parameter int unsigned TAG_W     = TAG_W_DEF,
   parameter int unsigned SLOT_W    = SLOT_W_DEF,
   parameter int unsigned NUM_SLOTS = NUM_SLOTS_DEF
)(
   input  logic                        bclk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic                        rdy_i,
   input  logic [NUM_SLOTS-1:0]        vld_i,
   input  logic [NUM_SLOTS*SLOT_W-1:0] data_i,
   output logic                        sdata_o
);
   localparam int unsigned FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
   localparam int unsigned PAD_W      = TAG_W - 1 - NUM_SLOTS;

   logic [FRAME_BITS-1:0] frame_vec;
   logic [FRAME_BITS-1:0] sreg;
   logic [CNT_W-1:0]      rem;

   assign frame_vec[FRAME_BITS-1] = rdy_i;
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign frame_vec[FRAME_BITS-2-s] = vld_i[s];
      assign frame_vec[(NUM_SLOTS-1-s)*SLOT_W +: SLOT_W] =
         vld_i[s] ? data_i[s*SLOT_W +: SLOT_W] : '0;
   end
   if (PAD_W > 0) begin : g_pad
      assign frame_vec[NUM_SLOTS*SLOT_W +: PAD_W] = '0;
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         sreg    <= '0;
         rem     <= '0;
         sdata_o <= 1'b0;
      end else if (start_i) begin
         sdata_o <= frame_vec[FRAME_BITS-1];
         sreg    <= {frame_vec[FRAME_BITS-2:0], 1'b0};
         rem     <= CNT_W'(FRAME_BITS - 1);
      end else if (rem != '0) begin
         sdata_o <= sreg[FRAME_BITS-1];
         sreg    <= {sreg[FRAME_BITS-2:0], 1'b0};
         rem     <= rem - CNT_W'(1);
      end else begin
         sdata_o <= 1'b0;
      end
   end

   AST_TAG_READY: assert property (@(posedge bclk) disable iff (!rst_n)
      start_i |=> sdata_o == $past(rdy_i)); // R3
endmodule

// File: rtl/aclink_warm.sv
module aclink_warm
   import aclink_pkg::*;
#(
   parameter int unsigned WARM_MIN = WARM_MIN_DEF
)(
   input  logic bclk,
   input  logic rst_n,
   input  logic sync_i,
   input  logic link_pd,
   output logic warm_o
);
   localparam int unsigned WCNT_W = $clog2(WARM_MIN + 1);
   localparam logic [WCNT_W-1:0] WARM_C = WCNT_W'(WARM_MIN);

   if (WARM_MIN < 1) begin : g_bad_min
      $error("aclink_warm: minimum pulse length must be at least one");
   end

   logic              sync_q;
   logic [WCNT_W-1:0] cnt;

   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         cnt    <= '0;
         warm_o <= 1'b0;
      end else begin
         sync_q <= sync_i;
         warm_o <= link_pd && sync_q && !sync_i && (cnt == WARM_C);
         if (!link_pd || !sync_i) cnt <= '0;
         else if (cnt != WARM_C)  cnt <= cnt + WCNT_W'(1);
      end
   end

   AST_WARM_IN_PD: assert property (@(negedge bclk) disable iff (!rst_n)
      warm_o |-> $past(link_pd)); // R8
   AST_WARM_AFTER_HIGH: assert property (@(negedge bclk) disable iff (!rst_n)
      warm_o |-> !$past(sync_i) && $past(sync_i, 2)); // R8
   AST_WARM_SINGLE: assert property (@(negedge bclk) disable iff (!rst_n)
      warm_o |=> !warm_o); // R8
endmodule

// File: rtl/aclink_codec_if.sv
module aclink_codec_if
   import aclink_pkg::*;
#(
   parameter int unsigned TAG_W        = TAG_W_DEF,
   parameter int unsigned SLOT_W       = SLOT_W_DEF,
   parameter int unsigned NUM_SLOTS    = NUM_SLOTS_DEF,
   parameter int unsigned SYNC_HIGH    = SYNC_HI_DEF,
   parameter int unsigned WARM_MIN     = WARM_MIN_DEF,
   parameter bit          ZERO_INVALID = 1'b1
)(
   input  logic                        bclk,
   input  logic                        rst_n,
   input  logic                        sync_in,
   input  logic                        ctl_sdata,
   input  logic                        link_pd,
   input  logic                        codec_rdy,
   input  logic [NUM_SLOTS-1:0]        tx_slot_vld,
   input  logic [NUM_SLOTS*SLOT_W-1:0] tx_slot_data,
   output logic                        codec_sdata,
   output logic                        rx_frame,
   output logic [TAG_W-1:0]            rx_tag,
   output logic [NUM_SLOTS-1:0]        rx_slot_vld,
   output logic [NUM_SLOTS*SLOT_W-1:0] rx_slot_data,
   output logic                        frame_err,
   output logic                        warm_rst
);
   logic frame_start;

   aclink_rx #(
      .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
      .SYNC_HIGH(SYNC_HIGH), .ZERO_INVALID(ZERO_INVALID)
   ) u_rx (
      .bclk(bclk), .rst_n(rst_n), .sync_i(sync_in), .sdata_i(ctl_sdata),
      .link_pd(link_pd), .start_o(frame_start), .frame_o(rx_frame),
      .err_o(frame_err), .tag_o(rx_tag), .vld_o(rx_slot_vld), .data_o(rx_slot_data)
   );

   aclink_tx #(
      .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
   ) u_tx (
      .bclk(bclk), .rst_n(rst_n), .start_i(frame_start), .rdy_i(codec_rdy),
      .vld_i(tx_slot_vld), .data_i(tx_slot_data), .sdata_o(codec_sdata)
   );

   aclink_warm #(
      .WARM_MIN(WARM_MIN)
   ) u_warm (
      .bclk(bclk), .rst_n(rst_n), .sync_i(sync_in), .link_pd(link_pd), .warm_o(warm_rst)
   );
endmodule

// File: tb/test_aclink_codec_if.sv
module test_aclink_codec_if;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 12;
   localparam int SW = 20;
   localparam int TW = 16;
   localparam int FB = TW + NS * SW;
   localparam int WARM_MIN = 4;

   logic              bclk = 1'b0;
   logic              rst_n;
   logic              sync_in;
   logic              ctl_sdata;
   logic              link_pd;
   logic              codec_rdy;
   logic [NS-1:0]     tx_slot_vld;
   logic [NS*SW-1:0]  tx_slot_data;
   logic              codec_sdata;
   logic              rx_frame;
   logic [TW-1:0]     rx_tag;
   logic [NS-1:0]     rx_slot_vld;
   logic [NS*SW-1:0]  rx_slot_data;
   logic              frame_err;
   logic              warm_rst;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [TW-1:0] c_tag;
   logic [SW-1:0] c_slot [NS];

   always #(CLK_PERIOD/2) bclk = ~bclk;

   aclink_codec_if i_aclink_codec_if (
      .bclk(bclk), .rst_n(rst_n), .sync_in(sync_in), .ctl_sdata(ctl_sdata),
      .link_pd(link_pd), .codec_rdy(codec_rdy), .tx_slot_vld(tx_slot_vld),
      .tx_slot_data(tx_slot_data), .codec_sdata(codec_sdata), .rx_frame(rx_frame),
      .rx_tag(rx_tag), .rx_slot_vld(rx_slot_vld), .rx_slot_data(rx_slot_data),
      .frame_err(frame_err), .warm_rst(warm_rst)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One frame (or a cut-short frame) as the controller, with a per-clock model compare
   task automatic run_frame(input int sync_len, input int stop_at, input string req);
      bit out_q[$];
      bit in_q[$];
      logic [FB-1:0]    got_in;
      logic [FB-1:0]    exp_in;
      logic [NS-1:0]    exp_vld;
      logic [NS*SW-1:0] exp_data;
      int  strobe_bad;
      int  err_bad;
      int  warm_bad;
      bit  full;
      bit  exp_f, exp_e, exp_w;
      strobe_bad = 0; err_bad = 0; warm_bad = 0;
      full = (stop_at > FB);
      got_in = '0;
      for (int k = TW-1; k >= 0; k--) out_q.push_back(c_tag[k]);
      for (int s = 0; s < NS; s++)
         for (int k = SW-1; k >= 0; k--) out_q.push_back(c_slot[s][k]);
      in_q.push_back(codec_rdy);
      for (int s = 0; s < NS; s++) in_q.push_back(tx_slot_vld[s]);
      for (int k = 0; k < 3; k++) in_q.push_back(1'b0);
      for (int s = 0; s < NS; s++)
         for (int k = SW-1; k >= 0; k--)
            in_q.push_back(tx_slot_vld[s] ? tx_slot_data[s*SW+k] : 1'b0);
      for (int b = 0; b < FB; b++) exp_in[FB-1-b] = link_pd ? 1'b0 : in_q[b];
      for (int s = 0; s < NS; s++) begin
         exp_vld[s] = c_tag[TW-2-s];
         exp_data[s*SW +: SW] = exp_vld[s] ? c_slot[s] : '0;
      end
      for (int b = 0; b < stop_at; b++) begin
         @(posedge bclk); #1;
         sync_in   = (b < sync_len);
         ctl_sdata = (b < FB) ? out_q[b] : 1'b0;
         @(negedge bclk); #1;
         exp_f = full && (b == FB-1) && !link_pd;
         exp_e = !link_pd && (b == sync_len) && (sync_len != 16);
         exp_w = link_pd && (b == sync_len) && (sync_len >= WARM_MIN);
         if (rx_frame !== exp_f)  strobe_bad++;
         if (frame_err !== exp_e) err_bad++;
         if (warm_rst !== exp_w)  warm_bad++;
         if (b >= 1 && b <= FB) got_in[FB-b] = codec_sdata;
         if (exp_f) begin
            check(rx_tag === c_tag, req, "rx_tag (R1)", 256'(rx_tag), 256'(c_tag));
            check(rx_slot_vld === exp_vld, req, "slot flags (R2)", 256'(rx_slot_vld), 256'(exp_vld));
            check(rx_slot_data === exp_data, req, "slot data (R1/R2)", 256'(rx_slot_data), 256'(exp_data));
         end
      end
      check(strobe_bad == 0, req, "cycles with wrong rx_frame", 256'(strobe_bad), 256'(0));
      check(err_bad == 0, req, "cycles with wrong frame_err (R5)", 256'(err_bad), 256'(0));
      check(warm_bad == 0, req, "cycles with wrong warm_rst (R8)", 256'(warm_bad), 256'(0));
      if (full)
         check(got_in === exp_in, req, "outgoing stream (R3/R4)", 256'(got_in), 256'(exp_in));
   endtask

   task automatic load_ctl(input logic [TW-1:0] tag, input logic [SW-1:0] seed);
      c_tag = tag;
      for (int s = 0; s < NS; s++) c_slot[s] = seed ^ SW'(s * 32'h1357) ^ SW'(s << 14);
   endtask

   initial begin
      #(CLK_PERIOD * 60000);
      if (!finished) begin
         n_fail++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sync_in = 1'b0; ctl_sdata = 1'b0; link_pd = 1'b0;
      codec_rdy = 1'b0; tx_slot_vld = '0; tx_slot_data = '0;
      for (int s = 0; s < NS; s++) c_slot[s] = '0;
      c_tag = '0;
      repeat (3) @(posedge bclk);
      @(negedge bclk); #1;
      check({codec_sdata, rx_frame, frame_err, warm_rst} === 4'b0, "R9", "control outputs in reset",
            256'({codec_sdata, rx_frame, frame_err, warm_rst}), 256'(0));
      @(posedge bclk); #1; rst_n = 1'b1;
      @(negedge bclk); #1;
      check(rx_tag === '0 && rx_slot_vld === '0 && rx_slot_data === '0, "R9", "data outputs after reset",
            256'(rx_slot_data), 256'(0));

      // R1 R3: all slots valid both ways
      load_ctl(16'hFFF8, 20'hA5C3E);
      codec_rdy = 1'b1; tx_slot_vld = '1;
      for (int s = 0; s < NS; s++) tx_slot_data[s*SW +: SW] = SW'(32'h8F00D + s * 32'h3A5);
      run_frame(16, FB+1, "R1");

      // R2 R4: mixed flags, invalid slots carry garbage on both sides
      load_ctl(16'b1_010101010101_101, 20'hFFFFF);
      codec_rdy = 1'b0; tx_slot_vld = 12'b1100_0011_0110;
      tx_slot_data = '1;
      run_frame(16, FB+1, "R2");
      load_ctl(16'b0_100000000001_000, 20'h0F0F1);
      tx_slot_vld = 12'b0000_0000_0001;
      run_frame(16, FB+1, "R4");

      // R5: short sync high run, frame still decoded
      load_ctl(16'hB6D0, 20'h12345);
      codec_rdy = 1'b1; tx_slot_vld = 12'hA5A;
      run_frame(10, FB+1, "R5");

      // R10: sync fall on the final bit collides with the frame strobe
      load_ctl(16'hFFF8, 20'h6789A);
      run_frame(255, FB+1, "R10");

      // R6: restart mid-frame and exactly at the last bit position
      load_ctl(16'hFFF8, 20'h33333);
      run_frame(16, 100, "R6");
      load_ctl(16'hC3C0, 20'h0ACE1);
      run_frame(16, FB+1, "R6");
      run_frame(16, FB-1, "R6");
      load_ctl(16'h9990, 20'hBEEF0);
      run_frame(16, FB+1, "R6");

      // R7: link powered down: full frame is ignored, outgoing line stays low
      link_pd = 1'b1;
      load_ctl(16'hFFF8, 20'h55555);
      run_frame(16, FB+1, "R7");

      // R8: warm-reset pulse lengths below, at and above the minimum
      run_frame(2, 6, "R8");
      run_frame(3, 8, "R8");
      run_frame(4, 8, "R8");
      run_frame(9, 12, "R8");

      // R7: decoding resumes once the link is back up
      link_pd = 1'b0;
      load_ctl(16'hE008, 20'h24680);
      tx_slot_vld = 12'h3C3;
      run_frame(16, FB+1, "R7");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule